// File: doc/BRIEF.md
# Iterative IDEA Block Encryptor

This core encrypts one 64-bit block under a 128-bit key with the IDEA cipher. It runs eight full rounds and then the closing half-round. It is built for a slow-clocked, area-starved host such as a passive tag. Every modular multiply in the cipher goes through one iterative modulo-65537 multiplier. Every 16-bit addition goes through one adder. Six 16-bit registers hold the working state. A host pulses `start_i` with the plaintext and key present. It waits a fixed number of cycles and then sees `done_o` pulse, with the ciphertext already on `cipher_o`.

A sequencer walks each round through eight micro-steps. Four are multiplies and four are adds. The last add also performs the round's XOR mixing and its middle-word swap. The closing half-round takes four more steps. The state machine has four states:
- **IDLE**: waits for a start.
- **ISSUE**: performs an add, or launches a multiply.
- **WAIT**: holds while a multiply completes.
- **DONE**: a single cycle that flags the result.

The transitions are:
- IDLE goes to ISSUE on an accepted start.
- ISSUE goes to WAIT when the current step is a multiply.
- ISSUE stays in ISSUE after an add that is not the final step, and goes to DONE after an add that is the final step.
- WAIT goes to ISSUE when the multiplier reports completion, or to DONE if that multiply was the final step.
- DONE always returns to IDLE.

Subkeys come from a 128-bit key register that is read 16 bits at a time, most significant first. The register rotates left by 25 bits each time eight subkeys have been used.

Top module: `idea_core`

## Requirements
- R1: After reset `done_o` is low and `cipher_o` is all zeros.
- R2: The ciphertext is standard IDEA encryption, defined as follows.
  - Round arithmetic: multiply modulo 65537, add modulo 65536, and XOR.
  - Subkey order: the key is taken as eight 16-bit subkeys, most significant first. The key is then rotated left by 25 and the next eight subkeys are taken, repeating until 52 have been used.
  - Word order: plaintext word 1 is bits 63:48, and the ciphertext uses the same word order.
  - Test vector: key 0x00010002000300040005000600070008 with plaintext 0x0000000100020003 gives 0x11FBED2B01986DE5.
- R3: A multiplier operand of 0 counts as 65536, and a product congruent to 65536 is delivered as 0. An all-zero key and block therefore encrypt correctly.
- R4: `done_o` is high exactly LAT cycles after the cycle in which an accepted `start_i` is high. LAT = 8*(4*M+4) + 2*M + 3, where M = ceil(17/MUL_DIGIT) + 2 is the cycle cost of one multiply. This gives 307 for MUL_DIGIT=3 and 205 for MUL_DIGIT=6.
- R5: `done_o` stays high for exactly one cycle per encryption.
- R6: `cipher_o` keeps its value from the `done_o` cycle until the next accepted start.
- R7: A `start_i` that arrives while the core is in ISSUE, WAIT or DONE is ignored. Plaintext and key are sampled only at an accepted start, so a later change to them affects neither the result nor the timing.
- R8: A start in the first cycle after `done_o` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an encryption; accepted only in IDLE |
| plain_i | input | 64 | Plaintext block, sampled at an accepted start |
| key_i | input | 128 | Cipher key, sampled at an accepted start |
| cipher_o | output | 64 | Ciphertext, valid from the `done_o` cycle |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench builds two copies of the core from the same stimulus. One uses MUL_DIGIT=3 (six-step multiply, 307-cycle latency) and one uses MUL_DIGIT=6 (three-step multiply, 205-cycle latency). The two latency formulas are therefore both checked.

Because the faster copy finishes while the slower one is still busy, a single start pulse can be aimed at the faster copy's DONE cycle while the slower copy is mid-computation. That one pulse probes the ignore rule in two different states at once. The same setup also lets the faster copy's result be checked long after its `done_o`, which covers the hold rule.

// File: rtl/idea_pkg.sv
package idea_pkg;
    localparam int W     = 16;
    localparam int BLK_W = 64;
    localparam int KEY_W = 128;
    localparam int ROT   = 25;
    localparam int STEP_W = 3;

    typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} idea_st_e;

    // Round steps 0,3,4,6 multiply; closing half-round steps 0,3 multiply.
    function automatic logic op_is_mul(input logic fin, input logic [STEP_W-1:0] s);
        if (fin) return (s == 3'd0) || (s == 3'd3);
        return (s == 3'd0) || (s == 3'd3) || (s == 3'd4) || (s == 3'd6);
    endfunction

    function automatic logic op_uses_key(input logic fin, input logic [STEP_W-1:0] s);
        if (fin) return 1'b1;
        return !((s == 3'd5) || (s == 3'd7));
    endfunction

    function automatic logic op_is_last(input logic fin, input logic [STEP_W-1:0] s);
        return fin ? (s == 3'd3) : (s == 3'd7);
    endfunction
endpackage

// File: rtl/idea_mulmod.sv
module idea_mulmod #(
    parameter int WD    = 16,
    parameter int DIGIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [WD-1:0] a_i,
    input  logic [WD-1:0] b_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [WD-1:0] res_o
);
    localparam int OPW   = WD + 1;
    localparam int STEPS = (OPW + DIGIT - 1) / DIGIT;
    localparam int PADW  = STEPS * DIGIT;
    localparam int PW    = 2 * WD + 1;
    localparam int CW    = $clog2(STEPS + 1);
    localparam logic [WD+1:0] MODV = (18'(1) << WD) + 18'd1;

    logic [OPW-1:0]  a_q;
    logic [PADW-1:0] b_q;
    logic [PW-1:0]   acc_q;
    logic [CW-1:0]   cnt_q;
    logic [PW-1:0]   part;
    logic [OPW-1:0]  a_ext, b_ext;

    assign a_ext = (a_i == '0) ? (OPW'(1) << WD) : {1'b0, a_i};
    assign b_ext = (b_i == '0) ? (OPW'(1) << WD) : {1'b0, b_i};
    assign part  = PW'(a_q) * PW'(b_q[PADW-1 -: DIGIT]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else if (go_i) begin
            a_q    <= a_ext;
            b_q    <= PADW'(b_ext);
            acc_q  <= '0;
            cnt_q  <= CW'(STEPS);
            done_o <= 1'b0;
        end else if (cnt_q != '0) begin
            acc_q  <= (acc_q << DIGIT) + part;
            b_q    <= b_q << DIGIT;
            cnt_q  <= cnt_q - 1'b1;
            done_o <= (cnt_q == CW'(1));
        end else begin
            done_o <= 1'b0;
        end
    end

    assign busy_o = (cnt_q != '0);

    // Low word minus high word, folded back into [0, 2^16].
    logic [WD:0]   hi;
    logic [WD-1:0] lo;
    logic [WD+1:0] diff;
    always_comb begin
        hi = acc_q[PW-1:WD];
        lo = acc_q[WD-1:0];
        if ({1'b0, lo} >= hi) diff = {2'b00, lo} - {1'b0, hi};
        else                  diff = {2'b00, lo} + MODV - {1'b0, hi};
        res_o = diff[WD-1:0];
    end
endmodule

// File: rtl/idea_keysched.sv
module idea_keysched #(
    parameter int KW  = 128,
    parameter int SW  = 16,
    parameter int RT  = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [KW-1:0] key_i,
    input  logic          adv_i,
    output logic [SW-1:0] sk_o
);
    localparam int NSK = KW / SW;
    localparam int IW  = $clog2(NSK);

    logic [KW-1:0] key_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            key_q <= key_i;
            idx_q <= '0;
        end else if (adv_i) begin
            if (idx_q == IW'(NSK - 1)) begin
                idx_q <= '0;
                key_q <= {key_q[KW-RT-1:0], key_q[KW-1:KW-RT]};
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign sk_o = key_q[(KW - 1) - SW * int'(idx_q) -: SW];
endmodule

// File: rtl/idea_datapath.sv
module idea_datapath #(
    parameter int WD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [4*WD-1:0] pt_i,
    input  logic            wr_i,
    input  logic            fin_i,
    input  logic [2:0]      step_i,
    input  logic [WD-1:0]   sk_i,
    input  logic [WD-1:0]   mres_i,
    output logic [WD-1:0]   mop_o,
    output logic [4*WD-1:0] ct_o
);
    logic [WD-1:0] x1, x2, x3, x4, t0, t1;
    logic [WD-1:0] add_a, add_b, sum;

    always_comb begin
        mop_o = x1;
        add_a = x2;
        add_b = sk_i;
        case (step_i)
            3'd1: add_a = fin_i ? x3 : x2;
            3'd2: add_a = fin_i ? x2 : x3;
            3'd3: mop_o = x4;
            3'd4: mop_o = x1 ^ x3;
            3'd5: begin add_a = x2 ^ x4; add_b = t0; end
            3'd6: mop_o = t1;
            3'd7: begin add_a = t0; add_b = t1; end
            default: mop_o = x1;
        endcase
    end

    assign sum = add_a + add_b;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {x1, x2, x3, x4, t0, t1} <= '0;
        end else if (load_i) begin
            {x1, x2, x3, x4} <= pt_i;
        end else if (wr_i) begin
            case (step_i)
                3'd0: x1 <= mres_i;
                3'd1: if (fin_i) x3 <= sum; else x2 <= sum;
                3'd2: if (fin_i) x2 <= sum; else x3 <= sum;
                3'd3: x4 <= mres_i;
                3'd4: t0 <= mres_i;
                3'd5: t1 <= sum;
                3'd6: t1 <= mres_i;
                3'd7: begin
                    x1 <= x1 ^ t1;
                    x2 <= x3 ^ t1;
                    x3 <= x2 ^ sum;
                    x4 <= x4 ^ sum;
                end
                default: x1 <= x1;
            endcase
        end
    end

    assign ct_o = {x1, x3, x2, x4};
endmodule

// File: rtl/idea_core.sv
module idea_core
    import idea_pkg::*;
#(
    parameter int MUL_DIGIT = 3,
    parameter int ROUNDS    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [BLK_W-1:0]   plain_i,
    input  logic [KEY_W-1:0]   key_i,
    output logic [BLK_W-1:0]   cipher_o,
    output logic               done_o
);
    localparam int RW = $clog2(ROUNDS);

    idea_st_e          st_q, st_d;
    logic [STEP_W-1:0] step_q;
    logic              fin_q;
    logic [RW-1:0]     rnd_q;

    logic op_mul, op_key, op_last;
    logic mul_go, mul_busy, mul_done, commit, key_adv, load, st_idle;
    logic [W-1:0] sk, mop, mres;

    assign op_mul  = op_is_mul(fin_q, step_q);
    assign op_key  = op_uses_key(fin_q, step_q);
    assign op_last = op_is_last(fin_q, step_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i) st_d = ST_ISSUE;
            ST_ISSUE: if (op_mul) st_d = ST_WAIT;
                      else if (op_last && fin_q) st_d = ST_DONE;
            ST_WAIT:  if (mul_done) st_d = (op_last && fin_q) ? ST_DONE : ST_ISSUE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        st_idle = (st_q == ST_IDLE);
        load    = st_idle && start_i;
        mul_go  = (st_q == ST_ISSUE) && op_mul;
        commit  = ((st_q == ST_ISSUE) && !op_mul) || ((st_q == ST_WAIT) && mul_done);
        key_adv = commit && op_key;
        done_o  = (st_q == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
            fin_q  <= 1'b0;
            rnd_q  <= '0;
        end else if (load) begin
            step_q <= '0;
            fin_q  <= 1'b0;
            rnd_q  <= '0;
        end else if (commit) begin
            if (op_last) begin
                step_q <= '0;
                if (!fin_q) begin
                    if (rnd_q == RW'(ROUNDS - 1)) fin_q <= 1'b1;
                    else                          rnd_q <= rnd_q + 1'b1;
                end
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    idea_keysched #(.KW(KEY_W), .SW(W), .RT(ROT)) u_ks (
        .clk(clk), .rst_n(rst_n), .load_i(load), .key_i(key_i),
        .adv_i(key_adv), .sk_o(sk)
    );

    idea_mulmod #(.WD(W), .DIGIT(MUL_DIGIT)) u_mul (
        .clk(clk), .rst_n(rst_n), .go_i(mul_go), .a_i(mop), .b_i(sk),
        .busy_o(mul_busy), .done_o(mul_done), .res_o(mres)
    );

    idea_datapath #(.WD(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load_i(load), .pt_i(plain_i),
        .wr_i(commit), .fin_i(fin_q), .step_i(step_q), .sk_i(sk),
        .mres_i(mres), .mop_o(mop), .ct_o(cipher_o)
    );
endmodule

// File: rtl/idea_core_chk.sv
module idea_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        done,
    input logic [63:0] ct,
    input logic        idle,
    input logic        mul_go,
    input logic        mul_busy,
    input logic        mul_done
);
    assert_mul_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> !mul_busy);

    assert_mul_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |=> !mul_done);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ct_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && $past(idle)) |-> $stable(ct));

    assert_busy_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !done && start) |=> !idle);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start) |=> !idle);
endmodule

bind idea_core idea_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start_i), .done(done_o), .ct(cipher_o),
    .idle(st_idle), .mul_go(mul_go), .mul_busy(mul_busy), .mul_done(mul_done)
);

// File: tb/idea_core_tb.sv
`timescale 1ns/1ps
module idea_core_tb;
    localparam int DA = 3;
    localparam int DB = 6;

    function automatic int lat_of(input int d);
        int m;
        m = (17 + d - 1) / d + 2;
        return 8 * (4 * m + 4) + 2 * m + 3;
    endfunction

    localparam int LAT_A = lat_of(DA);
    localparam int LAT_B = lat_of(DB);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n, start;
    logic [63:0]  pt;
    logic [127:0] key;
    logic [63:0]  ct_a, ct_b;
    logic         done_a, done_b;
    int checks = 0;
    int fails  = 0;

    idea_core #(.MUL_DIGIT(DA)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .plain_i(pt), .key_i(key),
        .cipher_o(ct_a), .done_o(done_a)
    );
    idea_core #(.MUL_DIGIT(DB)) u_dut_b (
        .clk(clk), .rst_n(rst_n), .start_i(start), .plain_i(pt), .key_i(key),
        .cipher_o(ct_b), .done_o(done_b)
    );

    function automatic logic [15:0] rmul(input logic [15:0] a, input logic [15:0] b);
        longint x, y, r;
        x = (a == 16'd0) ? 65536 : longint'(a);
        y = (b == 16'd0) ? 65536 : longint'(b);
        r = (x * y) % 65537;
        return 16'(r);
    endfunction

    function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [127:0] k);
        logic [15:0]  z [52];
        logic [127:0] kk;
        logic [15:0]  v1, v2, v3, v4, a, b, c, d, e, f, g, y2, y3;
        kk = k;
        for (int i = 0; i < 52; i++) begin
            z[i] = kk[127 - 16 * (i % 8) -: 16];
            if (i % 8 == 7) kk = {kk[102:0], kk[127:103]};
        end
        {v1, v2, v3, v4} = p;
        for (int r = 0; r < 8; r++) begin
            a = rmul(v1, z[6*r]);
            b = v2 + z[6*r+1];
            c = v3 + z[6*r+2];
            d = rmul(v4, z[6*r+3]);
            e = rmul(a ^ c, z[6*r+4]);
            f = rmul(16'((b ^ d) + e), z[6*r+5]);
            g = e + f;
            v1 = a ^ f; v2 = c ^ f; v3 = b ^ g; v4 = d ^ g;
        end
        y2 = v3 + z[49];
        y3 = v2 + z[50];
        return {rmul(v1, z[48]), y2, y3, rmul(v4, z[51])};
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Called just after a negedge; start is high for the following cycle.
    task automatic run(input logic [63:0] p, input logic [127:0] k, input bit poke, input string tag);
        logic [63:0] exp;
        int ka, kb, nb;
        exp = ref_enc(p, k);
        ka = 0; kb = 0; nb = 0;
        pt = p; key = k; start = 1'b1;
        for (int c = 1; c <= LAT_A; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (done_a && ka == 0) ka = c;
            if (done_b) begin nb++; if (kb == 0) kb = c; end
            if (poke && (c == 100 || c == LAT_B)) begin
                start = 1'b1; pt = ~p; key = ~k;
            end
        end
        start = 1'b0;
        check(ka == LAT_A, {"R4 latency digit3 ", tag}, ka, LAT_A);
        check(kb == LAT_B, {"R4 latency digit6 ", tag}, kb, LAT_B);
        check(nb == 1, {"R5 done pulse count ", tag}, nb, 1);
        check(ct_a == exp, {"R2 cipher digit3 ", tag}, ct_a, exp);
        check(ct_b == exp, {"R6 cipher held digit6 ", tag}, ct_b, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] hold;
        bit quiet_ok;
        rst_n = 1'b0; start = 1'b0; pt = '0; key = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_a && !done_b, "R1 done low after reset", {done_a, done_b}, 0);
        check(ct_a == 64'd0 && ct_b == 64'd0, "R1 cipher zero after reset", ct_a, 0);

        run(64'h0000000100020003, 128'h00010002000300040005000600070008, 1'b0, "vector");
        check(ct_a == 64'h11FBED2B01986DE5, "R2 published vector", ct_a, 64'h11FBED2B01986DE5);

        @(negedge clk);
        run(64'h0, 128'h0, 1'b0, "R3 all zero");
        check(ct_a == ref_enc(64'h0, 128'h0), "R3 zero operands", ct_a, ref_enc(64'h0, 128'h0));

        @(negedge clk);
        run(64'hFFFFFFFFFFFFFFFF, {128{1'b1}}, 1'b0, "all ones");

        @(negedge clk);
        run(64'hF129A6601EF62A47, 128'h2BD6459F82C5B300952C49104881FF48, 1'b1, "R7 stray starts");
        hold = ref_enc(64'hF129A6601EF62A47, 128'h2BD6459F82C5B300952C49104881FF48);
        quiet_ok = 1'b1;
        for (int q = 0; q < 12; q++) begin
            @(negedge clk);
            if (done_a || done_b || ct_a != hold || ct_b != hold) quiet_ok = 1'b0;
        end
        check(quiet_ok, "R6 R7 quiet hold after stray starts", ct_a, hold);

        // R8: restart in the first idle cycle after done
        @(negedge clk);
        run(64'h0123456789ABCDEF, 128'hFEDCBA9876543210_0F1E2D3C4B5A6978, 1'b0, "R8 first");
        @(negedge clk);
        run(64'h8000000000000001, 128'h0000FFFF00010000_8000000100000000, 1'b0, "R8 back to back");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule